// File: doc/BRIEF.md
# Variable-Group Carry-Select Adder with Add-One Conversion

This block is a purely combinational 16-bit adder. It takes two operands and a carry-in and produces a 16-bit sum and a carry-out, which together form the full 17-bit result. The operand is split into groups whose widths grow from the least significant end; a parameter sets the partition, and the default is 2, 2, 3, 4 and 5 bits.

The bottom group sees the real carry-in from the start, so it is a plain ripple adder. Each higher group does one ripple addition with an assumed carry-in of zero. It then builds its carry-in-of-one result by adding one to that zero-carry result (carry bit and sum bits together), using an incrementer rather than a second ripple adder. A 2:1 selector in each group picks one of the two results, driven by the selected carry of the group below. The last group's selected carry is the adder's carry-out.

A partition whose widths do not add up to the operand width stops elaboration with an error. The adder has no clock and no state, and its outputs follow its inputs.

Top module: `csel_excess_adder`

## Requirements
- R1: `{carryOut, sumOut}` equals `opA + opB + carryIn`, computed as a 17-bit unsigned value, for every input combination.
- R2: Sum bits 1..0 (the bottom group of the default partition) equal the low two bits of `opA[1:0] + opB[1:0] + carryIn`, whatever the upper operand bits are.
- R3: Each higher group's zero-carry result equals its operand slices added with carry-in 0, as a value one bit wider than the group. A group whose lower bits produce no carry shows exactly this result at the sum outputs.
- R4: Each higher group's one-carry result equals its zero-carry result plus one, modulo 2^(group width + 1). A group whose slice is all ones and which receives a carry outputs all zeros and passes a carry upward.
- R5: The carry selecting a group's result equals the true carry out of all bits below that group, including a carry generated inside the group just below without rippling from further down.
- R6: With both operands all ones and `carryIn` = 1 the result is sum 0xFFFF with carry-out 1. With `opA` = 0xFFFF, `opB` = 0 and `carryIn` = 1 the result is sum 0 with carry-out 1.
- R7: Under the default partition (group boundaries at bits 2, 4, 7 and 11, top group ending at bit 16), an input carry propagates across every group boundary. `opA` = 2^k - 1 with `opB` = 0 and `carryIn` = 1 gives the value 2^k for each boundary k.
- R8: The adder is combinational. A change at the inputs appears at the outputs within the same half clock period, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 16 | Low 16 bits of the result |
| carryOut | output | 1 | Bit 16 of the result |

## Verification
A fault inside a group appears at the ports at once, since there is no state: a broken incrementer corrupts that group's sum bits only when a carry arrives from below, and a wrong select carry corrupts every group above it. The stimulus therefore aims at the carry into each group: carries that ripple from bit 0, carries that a lower group generates itself, and all-ones slices that make the incrementer wrap. Each vector is checked half a period after it is applied and again after the next clock edge, so a result that depends on a clock or a stale value differs from the model.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Carry strobes a select group hands back to the top.
  typedef struct packed {
    logic zeroCarry;  // carry out assuming carry-in 0
    logic oneCarry;   // carry out assuming carry-in 1
    logic chosen;     // carry picked by the real carry-in
  } grpCarry_t;

endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W-1:0] sumOut,
  output logic         carryOut
);

  logic [W:0] chain;

  assign chain[0] = carryIn;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic half;
    assign half        = opA[i] ^ opB[i];
    assign sumOut[i]   = half ^ chain[i];
    assign chain[i+1]  = (opA[i] & opB[i]) | (half & chain[i]);
  end

  assign carryOut = chain[W];

endmodule

// File: rtl/csel_excess_one.sv
module csel_excess_one #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] valIn,
  output logic [W-1:0] valOut
);

  // Incrementer: a bit flips when every bit below it is one.
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign valOut[0] = ~valIn[0];
    end else begin : g_upper
      assign valOut[i] = valIn[i] ^ (&valIn[i-1:0]);
    end
  end

endmodule

// File: rtl/csel_group.sv
module csel_group #(
  parameter int unsigned W     = 4,
  parameter int unsigned PAD_W = 5
) (
  input  logic [W-1:0]        opA,
  input  logic [W-1:0]        opB,
  input  logic                selCarry,
  output logic [W-1:0]        sumOut,
  output csel_pkg::grpCarry_t carries,
  output logic [PAD_W:0]      zeroRes,
  output logic [PAD_W:0]      oneRes
);

  logic [W-1:0] zeroSum;
  logic         zeroCarry;
  logic [W:0]   oneVal;

  csel_ripple #(.W(W)) u_rca (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (1'b0),
    .sumOut   (zeroSum),
    .carryOut (zeroCarry)
  );

  csel_excess_one #(.W(W + 1)) u_inc (
    .valIn  ({zeroCarry, zeroSum}),
    .valOut (oneVal)
  );

  assign sumOut            = selCarry ? oneVal[W-1:0] : zeroSum;
  assign carries.zeroCarry = zeroCarry;
  assign carries.oneCarry  = oneVal[W];
  assign carries.chosen    = selCarry ? oneVal[W] : zeroCarry;

  if (W < PAD_W) begin : g_pad
    assign zeroRes = {{(PAD_W - W){1'b0}}, zeroCarry, zeroSum};
    assign oneRes  = {{(PAD_W - W){1'b0}}, oneVal};
  end else begin : g_nopad
    assign zeroRes = {zeroCarry, zeroSum};
    assign oneRes  = oneVal;
  end

endmodule

// File: rtl/csel_excess_adder.sv
module csel_excess_adder #(
  parameter int unsigned DATA_W                = 16,
  parameter int unsigned NUM_GROUPS            = 5,
  parameter int unsigned GROUP_W [NUM_GROUPS]  = '{2, 2, 3, 4, 5}
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] sumOut,
  output logic              carryOut
);

  function automatic int unsigned offsetOf(int unsigned k);
    int unsigned s = 0;
    for (int unsigned j = 0; j < k; j++) s += GROUP_W[j];
    return s;
  endfunction

  function automatic int unsigned widestGroup();
    int unsigned m = 1;
    for (int unsigned j = 0; j < NUM_GROUPS; j++)
      if (GROUP_W[j] > m) m = GROUP_W[j];
    return m;
  endfunction

  localparam int unsigned TOTAL_W = offsetOf(NUM_GROUPS);
  localparam int unsigned PAD_W   = widestGroup();

  if (TOTAL_W != DATA_W) begin : g_bad_partition
    $error("group widths sum to %0d, operand width is %0d", TOTAL_W, DATA_W);
  end

  logic [NUM_GROUPS:0]  grpCarry;
  logic [PAD_W:0]       zeroRes   [NUM_GROUPS];
  logic [PAD_W:0]       oneRes    [NUM_GROUPS];
  csel_pkg::grpCarry_t  grpStrobe [NUM_GROUPS];

  assign grpCarry[0] = carryIn;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int unsigned LO = offsetOf(g);
    localparam int unsigned W  = GROUP_W[g];

    if (g == 0) begin : g_base
      csel_ripple #(.W(W)) u_base (
        .opA      (opA[LO +: W]),
        .opB      (opB[LO +: W]),
        .carryIn  (grpCarry[0]),
        .sumOut   (sumOut[LO +: W]),
        .carryOut (grpCarry[1])
      );
      assign zeroRes[0]   = '0;
      assign oneRes[0]    = '0;
      assign grpStrobe[0] = '0;
    end else begin : g_sel
      csel_group #(.W(W), .PAD_W(PAD_W)) u_grp (
        .opA      (opA[LO +: W]),
        .opB      (opB[LO +: W]),
        .selCarry (grpCarry[g]),
        .sumOut   (sumOut[LO +: W]),
        .carries  (grpStrobe[g]),
        .zeroRes  (zeroRes[g]),
        .oneRes   (oneRes[g])
      );
      assign grpCarry[g+1] = grpStrobe[g].chosen;
    end
  end

  assign carryOut = grpCarry[NUM_GROUPS];

endmodule

// File: rtl/csel_excess_adder_chk.sv
module csel_excess_adder_chk #(
  parameter int unsigned DATA_W               = 16,
  parameter int unsigned NUM_GROUPS           = 5,
  parameter int unsigned GROUP_W [NUM_GROUPS] = '{2, 2, 3, 4, 5},
  parameter int unsigned PAD_W                = 5
) (
  input logic [DATA_W-1:0]  opA,
  input logic [DATA_W-1:0]  opB,
  input logic               carryIn,
  input logic [DATA_W-1:0]  sumOut,
  input logic               carryOut,
  input logic [NUM_GROUPS:0] grpCarry,
  input logic [PAD_W:0]     zeroRes   [NUM_GROUPS],
  input logic [PAD_W:0]     oneRes    [NUM_GROUPS],
  input csel_pkg::grpCarry_t grpStrobe [NUM_GROUPS]
);

  function automatic int unsigned offsetOf(int unsigned k);
    int unsigned s = 0;
    for (int unsigned j = 0; j < k; j++) s += GROUP_W[j];
    return s;
  endfunction

  logic [DATA_W:0] fullRef;
  logic [63:0]     sliceA, sliceB, zeroExp, oneExp, lowMask, lowSum, upTotal;
  logic [63:0]     baseMask, baseSum;

  always_comb begin
    fullRef  = '0;
    sliceA   = '0;
    sliceB   = '0;
    zeroExp  = '0;
    oneExp   = '0;
    lowMask  = '0;
    lowSum   = '0;
    upTotal  = '0;
    baseMask = '0;
    baseSum  = '0;
    if (!$isunknown({opA, opB, carryIn})) begin
      fullRef = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn};
      p_full_sum_r1: assert ({carryOut, sumOut} == fullRef)
        else $error("R1 result %h expected %h", {carryOut, sumOut}, fullRef);

      baseMask = (64'd1 << GROUP_W[0]) - 64'd1;
      baseSum  = (64'(opA) & baseMask) + (64'(opB) & baseMask) + 64'(carryIn);
      p_base_group_r2: assert ((64'(sumOut) & baseMask) == (baseSum & baseMask))
        else $error("R2 bottom group mismatch");

      for (int unsigned g = 1; g < NUM_GROUPS; g++) begin
        sliceA  = (64'(opA) >> offsetOf(g)) & ((64'd1 << GROUP_W[g]) - 64'd1);
        sliceB  = (64'(opB) >> offsetOf(g)) & ((64'd1 << GROUP_W[g]) - 64'd1);
        zeroExp = sliceA + sliceB;
        oneExp  = (zeroExp + 64'd1) & ((64'd1 << (GROUP_W[g] + 1)) - 64'd1);
        p_zero_res_r3: assert (zeroRes[g] == zeroExp[PAD_W:0] &&
                               grpStrobe[g].zeroCarry == zeroExp[GROUP_W[g]])
          else $error("R3 group %0d zero-carry result %h expected %h", g, zeroRes[g], zeroExp[PAD_W:0]);
        p_one_res_r4: assert (oneRes[g] == oneExp[PAD_W:0] &&
                              grpStrobe[g].oneCarry == oneExp[GROUP_W[g]])
          else $error("R4 group %0d one-carry result %h expected %h", g, oneRes[g], oneExp[PAD_W:0]);

        lowMask = (64'd1 << offsetOf(g)) - 64'd1;
        lowSum  = (64'(opA) & lowMask) + (64'(opB) & lowMask) + 64'(carryIn);
        upTotal = lowSum + (zeroExp << offsetOf(g));
        p_sel_carry_r5: assert (grpCarry[g] == lowSum[offsetOf(g)] &&
                                grpStrobe[g].chosen == upTotal[offsetOf(g) + GROUP_W[g]])
          else $error("R5 group %0d select carry wrong", g);
      end
    end
  end

endmodule

bind csel_excess_adder csel_excess_adder_chk #(
  .DATA_W     (DATA_W),
  .NUM_GROUPS (NUM_GROUPS),
  .GROUP_W    (GROUP_W),
  .PAD_W      (PAD_W)
) u_chk (
  .opA       (opA),
  .opB       (opB),
  .carryIn   (carryIn),
  .sumOut    (sumOut),
  .carryOut  (carryOut),
  .grpCarry  (grpCarry),
  .zeroRes   (zeroRes),
  .oneRes    (oneRes),
  .grpStrobe (grpStrobe)
);

// File: tb/sim_csel_excess_adder.sv
`timescale 1ns/1ps
module sim_csel_excess_adder;

  typedef struct {
    logic [15:0] a;
    logic [15:0] b;
    logic        c;
    string       tag;
  } vec_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [15:0] sumOut;
  logic        carryOut;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;
  vec_t stimQ[$];

  always #5 clk = ~clk;

  csel_excess_adder u0 (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  task automatic checkEq(input string req, input logic [16:0] act, input logic [16:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic [15:0] b, input logic c, input string tag);
    vec_t v;
    v.a = a; v.b = b; v.c = c; v.tag = tag;
    stimQ.push_back(v);
  endtask

  function automatic logic [16:0] refAdd(input logic [15:0] a, input logic [15:0] b, input logic c);
    int unsigned t;
    t = int'(a) + int'(b) + int'(c);
    return t[16:0];
  endfunction

  initial begin : driver
    vec_t v;
    int boundary [4] = '{2, 4, 7, 11};
    int widths   [4] = '{2, 3, 4, 5};
    logic [16:0] exp;

    // R1 zero operands
    push(16'h0000, 16'h0000, 1'b0, "R1 zero");
    push(16'h0000, 16'h0000, 1'b1, "R1 zero+cin");
    // R6 saturation corners
    push(16'hFFFF, 16'hFFFF, 1'b1, "R6 ones+ones+1");
    push(16'hFFFF, 16'h0000, 1'b1, "R6 ones+1");
    push(16'hFFFF, 16'hFFFF, 1'b0, "R6 ones+ones");
    // R7 carry rippling from bit 0 across each boundary, and the top
    foreach (boundary[i]) push(16'((32'd1 << boundary[i]) - 1), 16'h0000, 1'b1, "R7 boundary");
    push(16'hFFFF, 16'h0000, 1'b1, "R7 top boundary");
    // R5 carry generated just below each boundary
    foreach (boundary[i]) push(16'(32'd1 << (boundary[i] - 1)), 16'(32'd1 << (boundary[i] - 1)), 1'b0, "R5 generated carry");
    // R4 all-ones group slice receiving a carry, wraps to zero
    foreach (boundary[i])
      push(16'(((32'd1 << widths[i]) - 1) << boundary[i] | ((32'd1 << boundary[i]) - 1)), 16'h0000, 1'b1, "R4 wrap");
    // R3 group slices added with no carry from below
    foreach (boundary[i])
      for (int k = 0; k < 4; k++)
        push(16'($urandom() & (((32'd1 << widths[i]) - 1) << boundary[i])),
             16'($urandom() & (((32'd1 << widths[i]) - 1) << boundary[i])), 1'b0, "R3 slice no carry");
    // R2 bottom group isolated from upper bits
    for (int k = 0; k < 8; k++) push(16'($urandom()), 16'($urandom()), k[0], "R2 random upper");
    // R1 random
    for (int k = 0; k < 200; k++) push(16'($urandom()), 16'($urandom()), 1'($urandom()), "R1 random");

    // reset phase: inputs held at zero
    repeat (3) @(posedge clk);
    #2;
    checkEq("R1 reset-state output", {carryOut, sumOut}, 17'h0);
    rst = 1'b0;

    while (stimQ.size() > 0) begin
      v = stimQ.pop_front();
      @(negedge clk);
      opA = v.a; opB = v.b; carryIn = v.c;
      exp = refAdd(v.a, v.b, v.c);
      #2;  // R8 no edge since the change
      checkEq({"R8 comb ", v.tag}, {carryOut, sumOut}, exp);
      @(posedge clk);
      #2;
      checkEq(v.tag, {carryOut, sumOut}, exp);
      checkEq("R2 bottom bits", {15'h0, sumOut[1:0]}, {15'h0, 2'(int'(v.a[1:0]) + int'(v.b[1:0]) + int'(v.c))});
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin : watchdog
    #1_000_000;
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule